// File: doc/BRIEF.md
# Serial Opcode Display Command Receiver

This block receives commands for an eight-character dot-matrix display over a three-wire serial link made of a data line, a serial clock and a load strobe. The three serial lines are synchronized into the system clock domain. Each 8-bit word is shifted in with its least significant bit first. The rising edge of the load strobe ends the word and commits it. The top three bits of the word form an opcode, and that opcode routes the five payload bits to one of four places: a row of the dot memory, the character address, a clear action, or the control state (brightness, lamp test, power down).

The dot memory holds one 5-bit column pattern for each row of each character, 200 dots in all. A combinational read port lets the display scanner fetch any row. Brightness level, lamp test and power down leave the block as plain outputs, and so does the current character address, so that the LED driving logic can act on them.

Top module: `dot_cmd_rx`

## Requirements
- R1: While and after the asynchronous active-low reset, every memory row reads 0, `char_addr` is 0, `bright_lvl` is 0 (full brightness), and `lamp_test` and `power_down` are 0.
- R2: A bit is shifted in only on a rising edge of `ser_clk` that occurs while `ser_load` is low. The first bit shifted becomes bit 0 of the word and the eighth becomes bit 7. Serial clock edges while `ser_load` is high leave the held word unchanged.
- R3: A word whose bits 7..5 equal a row number 0..4 stores bits 4..0 into that row of the addressed character. Word bit 4 is column 0 and appears on `rd_cols[4]`.
- R4: Words 0xA0..0xA7 set `char_addr` to bits 2..0. Words 0xA8..0xBF change nothing.
- R5: Word 0xC0 zeroes every memory row and sets `char_addr` to 0. It leaves `bright_lvl`, `lamp_test` and `power_down` unchanged.
- R6: Words 0xF0..0xF6 set `bright_lvl` to bits 2..0 and clear both `lamp_test` and `power_down`.
- R7: Word 0xF8 sets `lamp_test` and clears `power_down`. It leaves `bright_lvl` unchanged.
- R8: Word 0xFF sets `power_down` and clears `lamp_test`. It leaves `bright_lvl` unchanged. Row writes and address loads are still accepted in power down.
- R9: Words 0xC1..0xEF, 0xF7 and 0xF9..0xFE change no memory row and no output.
- R10: The read port returns the stored row of character `rd_char` at row `rd_row`, and returns 0 when `rd_row` is 5 or more.
- R11: `lamp_test` and `power_down` are never high together, and all committed state changes only on a synchronized rising edge of the load line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_load | input | 1 | Load strobe: low enables shifting, rising edge commits |
| rd_char | input | 3 | Scanner read: character index |
| rd_row | input | 3 | Scanner read: row index |
| rd_cols | output | 5 | Scanner read data, bit 4 = column 0 |
| char_addr | output | 3 | Current character address |
| bright_lvl | output | 3 | Brightness level, 0 = full |
| lamp_test | output | 1 | Lamp test active |
| power_down | output | 1 | Power down active |

## Verification
The hardest case to reach is serial clock activity while the load line is high. From the ports this stimulus looks identical to a normal shift, so only its absence of effect reveals it. The stimulus commits a known address word, toggles the serial clock eight times with a pattern that would form a different address word, and then opens and closes the load line with no clock edges. If the re-decoded word still selects the first address, no shifting occurred. The remaining sweeps cover every undefined code and write all 40 rows. Power down is followed by memory writes, and the brightness, lamp test and power down changes are checked against each other.

// File: rtl/dot_cmd_rx.sv
module dot_cmd_rx #(
  parameter int NCHAR = 8,
  parameter int NROW  = 5,
  parameter int NCOL  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_data,
  input  logic       ser_load,
  input  logic [2:0] rd_char,
  input  logic [2:0] rd_row,
  output logic [4:0] rd_cols,
  output logic [2:0] char_addr,
  output logic [2:0] bright_lvl,
  output logic       lamp_test,
  output logic       power_down
);
  localparam int DEPTH = NCHAR * NROW;
  localparam int MW    = $clog2(DEPTH);

  logic [2:0] sck_q, ld_q;
  logic [1:0] dat_q;
  logic [7:0] sr;
  logic [NCOL-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      ld_q  <= 3'b111;
      dat_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], ser_clk};
      ld_q  <= {ld_q[1:0], ser_load};
      dat_q <= {dat_q[0], ser_data};
    end

  wire sc_rise = sck_q[1] & ~sck_q[2];
  wire ld_rise = ld_q[1] & ~ld_q[2];
  wire shift_en = sc_rise & ~ld_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sr <= '0;
    else if (shift_en) sr <= {dat_q[1], sr[7:1]};

  wire [2:0] op = sr[7:5];
  wire [4:0] pl = sr[4:0];
  wire is_row  = ld_rise & (int'(op) < NROW);
  wire is_addr = ld_rise & (op == 3'd5) & (pl[4:3] == 2'b00);
  wire is_clr  = ld_rise & (sr == 8'hC0);
  wire is_bri  = ld_rise & (op == 3'd7) & (pl[4:3] == 2'b10) & (pl[2:0] != 3'd7);
  wire is_lt   = ld_rise & (sr == 8'hF8);
  wire is_pd   = ld_rise & (sr == 8'hFF);

  wire [MW-1:0] wr_idx = MW'(char_addr) * MW'(NROW) + MW'(op);
  wire [MW-1:0] rd_idx = MW'(rd_char) * MW'(NROW) + MW'(rd_row);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (is_clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (is_row) begin
      mem[wr_idx] <= pl[NCOL-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) char_addr <= '0;
    else if (is_clr) char_addr <= '0;
    else if (is_addr) char_addr <= pl[2:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bright_lvl <= '0;
      lamp_test  <= 1'b0;
      power_down <= 1'b0;
    end else if (is_bri) begin
      bright_lvl <= pl[2:0];
      lamp_test  <= 1'b0;
      power_down <= 1'b0;
    end else if (is_lt) begin
      lamp_test  <= 1'b1;
      power_down <= 1'b0;
    end else if (is_pd) begin
      lamp_test  <= 1'b0;
      power_down <= 1'b1;
    end

  assign rd_cols = (int'(rd_row) < NROW) ? mem[rd_idx] : '0;
endmodule

module dot_cmd_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ld_rise,
  input logic       shift_en,
  input logic [7:0] sr,
  input logic [2:0] char_addr,
  input logic [2:0] bright_lvl,
  input logic       lamp_test,
  input logic       power_down
);
  // R11
  excl_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lamp_test && power_down));
  // R2
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr));
  // R11
  addr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_rise |=> $stable(char_addr));
  // R11
  ctrl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_rise |=> ($stable(bright_lvl) && $stable(lamp_test) && $stable(power_down)));
  // R5
  clear_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && sr == 8'hC0) |=> (char_addr == 3'd0));
  // R8
  pd_keep_bri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_down) |-> $stable(bright_lvl));
  // R7
  lt_keep_bri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lamp_test) |-> $stable(bright_lvl));
endmodule

bind dot_cmd_rx dot_cmd_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_rise(ld_rise), .shift_en(shift_en), .sr(sr),
  .char_addr(char_addr), .bright_lvl(bright_lvl), .lamp_test(lamp_test),
  .power_down(power_down)
);

// File: tb/dot_cmd_rx_tb.sv
module dot_cmd_rx_tb;
  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_data = 0, ser_load = 1;
  logic [2:0] rd_char = 0, rd_row = 0;
  logic [4:0] rd_cols;
  logic [2:0] char_addr, bright_lvl;
  logic lamp_test, power_down;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dot_cmd_rx u_dut (.*);

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    ser_load = 0;
    wclk(3);
    for (int i = 0; i < 8; i++) begin
      ser_data = b[i];
      wclk(3);
      ser_clk = 1;
      wclk(3);
      ser_clk = 0;
    end
    wclk(3);
    ser_load = 1;
    wclk(8);
  endtask

  function automatic logic [4:0] pat(int c, int r);
    return 5'((c * 7 + r * 3 + 1) & 31);
  endfunction

  task automatic rd_chk(string req, int c, int r, int exp);
    rd_char = 3'(c);
    rd_row = 3'(r);
    #1;
    chk(req, rd_cols, exp);
  endtask

  task automatic ctrl_chk(string req, int a, int b, int lt, int pd);
    chk(req, char_addr, a);
    chk(req, bright_lvl, b);
    chk(req, lamp_test, lt);
    chk(req, power_down, pd);
  endtask

  initial begin
    wclk(3);
    // R1 reset state
    ctrl_chk("R1", 0, 0, 0, 0);
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 5; r++) rd_chk("R1", c, r, 0);
    rst_n = 1;
    wclk(3);

    // R3 R4 fill every row of every character
    for (int c = 0; c < 8; c++) begin
      send(8'hA0 | 8'(c));
      chk("R4", char_addr, c);
      for (int r = 0; r < 5; r++) send({3'(r), pat(c, r)});
    end
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 5; r++) rd_chk("R3", c, r, pat(c, r));
    // R10 rows past the last read zero
    for (int r = 5; r < 8; r++) rd_chk("R10", 3, r, 0);

    // R3 column order: 0x10 lights column 0 only, at rd_cols[4]
    send(8'hA2);
    send(8'h10);
    rd_chk("R3", 2, 0, 5'b10000);

    // R4 out-of-range address codes ignored
    send(8'hA5);
    for (int v = 8'hA8; v <= 8'hBF; v++) begin
      send(8'(v));
      chk("R4", char_addr, 5);
    end

    // R6 brightness levels
    for (int v = 0; v < 7; v++) begin
      send(8'hF0 | 8'(v));
      ctrl_chk("R6", 5, v, 0, 0);
    end

    // R9 undefined codes leave all state alone
    send(8'hF3);
    for (int v = 8'hC1; v <= 8'hFE; v++) begin
      if (v >= 8'hF0 && v <= 8'hF6) continue;
      if (v == 8'hF8) continue;
      send(8'(v));
      ctrl_chk("R9", 5, 3, 0, 0);
      rd_chk("R9", 2, 0, 5'b10000);
    end

    // R7 lamp test
    send(8'hF8);
    ctrl_chk("R7", 5, 3, 1, 0);
    // R8 power down and writes while powered down
    send(8'hFF);
    ctrl_chk("R8", 5, 3, 0, 1);
    send(8'hA1);
    send(8'h4A);
    chk("R8", char_addr, 1);
    rd_chk("R8", 1, 2, 5'h0A);
    chk("R8", power_down, 1);
    // R6 brightness leaves power down
    send(8'hF1);
    ctrl_chk("R6", 1, 1, 0, 0);
    send(8'hF8);
    send(8'hF4);
    ctrl_chk("R6", 1, 4, 0, 0);

    // R2 serial clocks while load high do not shift
    send(8'hA6);
    for (int i = 0; i < 8; i++) begin
      ser_data = 8'hA3 >> i;
      wclk(3);
      ser_clk = 1;
      wclk(3);
      ser_clk = 0;
    end
    wclk(3);
    ser_load = 0;
    wclk(6);
    ser_load = 1;
    wclk(8);
    chk("R2", char_addr, 6);

    // R5 software clear keeps control state
    send(8'hFF);
    send(8'hC0);
    ctrl_chk("R5", 0, 4, 0, 1);
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 5; r++) rd_chk("R5", c, r, 0);

    // R1 asynchronous reset mid-run
    send(8'hA4);
    send(8'h9F);
    send(8'hF2);
    #1 rst_n = 0;
    #1;
    ctrl_chk("R1", 0, 0, 0, 0);
    rd_chk("R1", 4, 4, 0);
    wclk(2);
    rst_n = 1;
    wclk(2);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule